// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block makes the replacement decision for an eight-way set-associative cache. For the set being looked up, it takes the per-way valid mask and the seven-bit tree pseudo-LRU state. It returns the way to evict on a fill. When the cache reports an access, meaning a hit or a fill, to a given way, the block also returns the state that the tree should hold afterwards. Empty ways are always filled before any valid line is displaced.

The decision and the update are purely combinational. By default the block also holds one seven-bit tree per set in a register array, addressed by a set index. That array is written in the cycle that an access is reported, and it is cleared by reset. With the array disabled, the caller supplies the tree on an input bus and stores the returned next state itself. In that mode the block has no state of any kind.

Top module: `plru8_victim`

## Requirements
- R1: When at least one bit of the valid mask is 0, `victim_way` is the lowest index whose valid bit is 0, regardless of the tree state.
- R2: When all eight valid bits are 1, the tree decides. If t0=1, it tests t2: t2=1 gives way 7 when t6=1 and way 6 otherwise; t2=0 gives way 5 when t5=1 and way 4 otherwise. If t0=0, it tests t1: t1=1 gives way 3 when t4=1 and way 2 otherwise; t1=0 gives way 1 when t3=1 and way 0 otherwise. Here tN is bit N of the tree.
- R3: With `acc_en`=1, `state_next` equals the current tree with some bits forced and all other bits kept.
  - Way 0 sets t0, t1 and t3.
  - Way 1 sets t0 and t1 and clears t3.
  - Way 2 sets t0 and t4 and clears t1.
  - Way 3 sets t0 and clears t1 and t4.
  - Way 4 clears t0, sets t2 and t5.
  - Way 5 clears t0, sets t2, clears t5.
  - Way 6 clears t0 and t2, sets t6.
  - Way 7 clears t0, t2 and t6.
- R4: With `acc_en`=0, `state_next` equals `state_cur`, and in array mode no stored tree changes.
- R5: With all ways valid, the tree produced by an access to way w never decodes to w, for every one of the 128 starting trees and every way.
- R6: In array mode, reset clears the tree of every set to 0.
- R7: In array mode, a reported access writes `state_next` into the addressed set at the next clock edge and leaves every other set unchanged.
- R8: In array mode, `state_cur` shows the stored tree of the set selected by `set_idx`, and `state_in` is ignored. With the array disabled, `state_cur` follows `state_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the per-set tree array |
| rst_n | input | 1 | Active-low reset, clears every stored tree |
| set_idx | input | SET_W | Set whose tree is read and updated (array mode) |
| state_in | input | 7 | Tree supplied by the caller when the array is disabled |
| valid_mask | input | 8 | Valid bit of each way in the addressed set |
| acc_en | input | 1 | An access (hit or fill) is reported this cycle |
| acc_way | input | 3 | Way that was accessed |
| victim_way | output | 3 | Way chosen for replacement |
| state_cur | output | 7 | Tree currently in effect for the set |
| state_next | output | 7 | Tree after the reported access |

## Verification
The bench first drives vectors in which the valid mask has holes in the lowest, middle and highest ways, including over a tree full of ones. A design that let the tree override an empty way would evict a live line while a free slot exists. Next, the bench sweeps every tree against every accessed way and decodes each result. A wrong mask or value would make some update point back at the way just used, so that way would be the next one evicted. The array tests write one set and read it and its neighbour, issue a cycle with no access, and reset after a write. These catch a write to the wrong row, a write without `acc_en`, and a reset that leaves old state behind.

// File: rtl/plru8_victim.sv
module plru8_victim #(
  parameter int NUM_SETS    = 128,
  parameter bit STATE_ARRAY = 1'b1,
  localparam int SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAYS       = 8,
  localparam int WAY_W      = $clog2(WAYS),
  localparam int TREE_W     = WAYS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_idx,
  input  logic [TREE_W-1:0] state_in,
  input  logic [WAYS-1:0]   valid_mask,
  input  logic              acc_en,
  input  logic [WAY_W-1:0]  acc_way,
  output logic [WAY_W-1:0]  victim_way,
  output logic [TREE_W-1:0] state_cur,
  output logic [TREE_W-1:0] state_next
);

  logic [TREE_W-1:0] force_mask, force_val;
  logic [WAY_W-1:0]  tree_pick, free_pick;
  logic              all_valid;

  always_comb begin
    unique case (acc_way)
      3'd0: begin force_mask = 7'b0001011; force_val = 7'b0001011; end
      3'd1: begin force_mask = 7'b0001011; force_val = 7'b0000011; end
      3'd2: begin force_mask = 7'b0010011; force_val = 7'b0010001; end
      3'd3: begin force_mask = 7'b0010011; force_val = 7'b0000001; end
      3'd4: begin force_mask = 7'b0100101; force_val = 7'b0100100; end
      3'd5: begin force_mask = 7'b0100101; force_val = 7'b0000100; end
      3'd6: begin force_mask = 7'b1000101; force_val = 7'b1000000; end
      default: begin force_mask = 7'b1000101; force_val = 7'b0000000; end
    endcase
  end

  assign state_next = acc_en ? ((state_cur & ~force_mask) | force_val) : state_cur;

  always_comb begin
    if (state_cur[0])
      tree_pick = state_cur[2] ? (state_cur[6] ? 3'd7 : 3'd6)
                               : (state_cur[5] ? 3'd5 : 3'd4);
    else
      tree_pick = state_cur[1] ? (state_cur[4] ? 3'd3 : 3'd2)
                               : (state_cur[3] ? 3'd1 : 3'd0);
  end

  always_comb begin
    free_pick = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!valid_mask[i]) free_pick = WAY_W'(i);
  end

  assign all_valid  = &valid_mask;
  assign victim_way = all_valid ? tree_pick : free_pick;

  generate
    if (STATE_ARRAY) begin : g_array
      logic [TREE_W-1:0] tree_q [NUM_SETS];
      logic              unused_in;

      assign unused_in = ^state_in;
      assign state_cur = tree_q[set_idx];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
        end else if (acc_en) begin
          tree_q[set_idx] <= state_next;
        end
      end
    end else begin : g_pass
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ (^set_idx);
      assign state_cur = state_in;
    end
  endgenerate

endmodule

module plru8_victim_chk #(
  parameter int NUM_SETS    = 128,
  parameter bit STATE_ARRAY = 1'b1,
  localparam int SET_W      = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SET_W-1:0] set_idx,
  input logic [7:0]       valid_mask,
  input logic             acc_en,
  input logic [2:0]       acc_way,
  input logic [2:0]       victim_way,
  input logic [6:0]       state_cur,
  input logic [6:0]       state_next
);

  // R1
  empty_way_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_mask != 8'hFF) |-> (valid_mask[victim_way] == 1'b0));

  // R3
  root_bit_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> (state_next[0] == ~acc_way[2]));

  // R3
  other_half_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_way[2]) |-> (state_next[6:5] == state_cur[6:5] && state_next[2] == state_cur[2]));

  // R4
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (state_next == state_cur));

  // R5
  just_used_spared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && valid_mask == 8'hFF) |-> (state_next[0] != acc_way[2]));

  generate
    if (STATE_ARRAY) begin : g_arr_chk
      // R6
      reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (state_cur == 7'd0));

      // R7
      write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_en) && set_idx == $past(set_idx)) |-> (state_cur == $past(state_next)));

      // R8
      hold_same_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(acc_en) && $stable(set_idx)) |-> $stable(state_cur));
    end
  endgenerate

endmodule

bind plru8_victim plru8_victim_chk #(.NUM_SETS(NUM_SETS), .STATE_ARRAY(STATE_ARRAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .valid_mask(valid_mask),
  .acc_en(acc_en), .acc_way(acc_way), .victim_way(victim_way),
  .state_cur(state_cur), .state_next(state_next)
);

// File: tb/plru8_victim_tb.sv
module plru8_victim_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int errs = 0;
  int checks = 0;

  logic [6:0] a_set = '0, c_set = '0;
  logic [6:0] a_sin = '0, c_sin = '0;
  logic [7:0] a_val = 8'hFF, c_val = 8'hFF;
  logic       a_en = 1'b0, c_en = 1'b0;
  logic [2:0] a_way = '0, c_way = '0;
  logic [2:0] a_vic, c_vic;
  logic [6:0] a_cur, c_cur, a_nxt, c_nxt;

  plru8_victim #(.NUM_SETS(128), .STATE_ARRAY(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_idx(a_set), .state_in(a_sin), .valid_mask(a_val),
    .acc_en(a_en), .acc_way(a_way), .victim_way(a_vic), .state_cur(a_cur), .state_next(a_nxt));

  plru8_victim #(.NUM_SETS(128), .STATE_ARRAY(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .set_idx(c_set), .state_in(c_sin), .valid_mask(c_val),
    .acc_en(c_en), .acc_way(c_way), .victim_way(c_vic), .state_cur(c_cur), .state_next(c_nxt));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {valid, tree, acc_en, acc_way, expected victim, expected next tree}
  localparam logic [28:0] VEC [13] = '{
    {8'h00, 7'd0,   1'b0, 3'd0, 3'd0, 7'd0},
    {8'h0F, 7'd0,   1'b1, 3'd3, 3'd4, 7'd1},
    {8'hFE, 7'd127, 1'b1, 3'd5, 3'd0, 7'd94},
    {8'h7F, 7'd0,   1'b1, 3'd7, 3'd7, 7'd0},
    {8'h80, 7'd127, 1'b0, 3'd2, 3'd0, 7'd127},
    {8'hFF, 7'd0,   1'b1, 3'd0, 3'd0, 7'd11},
    {8'hFF, 7'd11,  1'b1, 3'd4, 3'd4, 7'd46},
    {8'hFF, 7'd46,  1'b1, 3'd2, 3'd2, 7'd61},
    {8'hFF, 7'd127, 1'b1, 3'd6, 3'd7, 7'd122},
    {8'hFF, 7'd122, 1'b0, 3'd6, 3'd3, 7'd122},
    {8'hFF, 7'd37,  1'b1, 3'd1, 3'd6, 7'd39},
    {8'hFF, 7'd8,   1'b1, 3'd3, 3'd1, 7'd9},
    {8'hFF, 7'd33,  1'b1, 3'd5, 3'd5, 7'd4}
  };

  initial begin
    logic [7:0] v; logic [6:0] s, n; logic e; logic [2:0] w, ev;

    // Table walk on the stateless instance: R1 (holes), R2 (tree), R3/R4 (update), R8 (pass-through)
    for (int k = 0; k < 13; k++) begin
      {v, s, e, w, ev, n} = VEC[k];
      c_val = v; c_sin = s; c_en = e; c_way = w;
      #5;
      check((v == 8'hFF) ? "R2 victim" : "R1 victim", c_vic, ev);
      check(e ? "R3 next" : "R4 next", c_nxt, n);
      check("R8 pass-through", c_cur, s);
    end

    // R5: exhaustive sweep, the accessed way is never the next victim
    c_val = 8'hFF; c_en = 1'b1;
    for (int st = 0; st < 128; st++) begin
      for (int wy = 0; wy < 8; wy++) begin
        c_sin = 7'(st); c_way = 3'(wy);
        #2;
        n = c_nxt;
        c_sin = n;
        #2;
        checks++;
        if (c_vic == 3'(wy)) begin
          errs++;
          $display("FAIL R5: tree=%0d way=%0d victim actual=%0d expected not %0d", st, wy, c_vic, wy);
        end
      end
    end

    // Array instance
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R6 set0 after reset", a_cur, 0);
    a_set = 7'd5;   #1; check("R6 set5 after reset", a_cur, 0);
    a_set = 7'd127; #1; check("R6 set127 after reset", a_cur, 0);

    // R7: write set 5 through way 0
    @(negedge clk) begin a_set = 7'd5; a_en = 1'b1; a_way = 3'd0; end
    @(negedge clk) a_en = 1'b0;
    #1; check("R7 set5 written", a_cur, 11);
    check("R2 array victim", a_vic, 4);
    a_set = 7'd6; #1; check("R7 set6 untouched", a_cur, 0);
    a_set = 7'd4; #1; check("R7 set4 untouched", a_cur, 0);

    // R8: state_in ignored in array mode
    a_set = 7'd5; a_sin = 7'd127; #1;
    check("R8 state_in ignored", a_cur, 11);

    // R4: cycle with acc_en low leaves stored tree
    @(negedge clk) begin a_way = 3'd7; a_en = 1'b0; end
    @(negedge clk); #1;
    check("R4 no write when idle", a_cur, 11);

    // R7: second update on top of stored value, way 4
    @(negedge clk) begin a_way = 3'd4; a_en = 1'b1; end
    @(negedge clk) a_en = 1'b0;
    #1; check("R7 chained update", a_cur, 46);

    // R6: reset after writes clears
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #1; check("R6 cleared after write", a_cur, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule